// File: doc/BRIEF.md
# Triple Readback Stream Voter

This block watches three devices that hold the same configuration and run in lockstep. Their configuration contents are read back serially, and the block votes on the three streams bit by bit without ever stopping the devices. When every bit of a pass agrees, nothing is reported. When one stream alone departs from the other two, that device is marked as upset. At the close of the pass, exactly one refresh request is issued for that device and for no other.

A pass, called a frame, is a fixed number of valid bits counted under a shared strobe. Cycles without the strobe are ignored. At the end of each frame the block pulses a frame-complete output and begins the next pass on its own. A device being refreshed is left out of the vote for the whole frame after its request, and rejoins at the following frame boundary. A disagreement the vote cannot resolve raises a sticky fatal flag in place of any refresh request. Two such cases exist: a second device going astray in the same frame, or the two remaining devices splitting while a third is left out.

Top module: `triple_readback_voter`

## Requirements
- R1: A frame is FRAME_BITS cycles with `rb_valid` high. Cycles with `rb_valid` low neither advance the count nor take part in the vote. `frame_done` is high for exactly one cycle, the cycle after the FRAME_BITS-th valid bit.
- R2: Valid bits on which all three voting devices agree raise no `upset_flag`, no `refresh_pulse` and no `fatal_mismatch`.
- R3: When all three devices vote and bit k of `rb_bits` is the only one that differs, `upset_flag[k]` goes high in the cycle after that bit. At most one `upset_flag` bit is ever high.
- R4: An upset device k gets exactly one single-cycle `refresh_pulse[k]`, however many of its bits mismatched. The pulse coincides with `frame_done` of the frame in which the upset was seen.
- R5: During the frame after its pulse, device k is left out of the vote and its mismatches have no effect. `upset_flag[k]` stays high through that frame and clears together with that frame's `frame_done`, without a further pulse.
- R6: If a second device becomes the lone outlier in a frame that already has an upset device, `fatal_mismatch` rises the cycle after that bit and stays high until reset. No `refresh_pulse` is issued at that frame's end, and the pending `upset_flag` clears then.
- R7: While one device is left out of the vote, a disagreement between the other two raises `fatal_mismatch` the next cycle.
- R8: Once `fatal_mismatch` is high, the vote stops: no new `upset_flag` and no `refresh_pulse` occur, while `frame_done` keeps marking frames.
- R9: While `rst_n` is low and in the first cycle after it, all outputs are low and the bit count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rb_bits | input | 3 | Current readback bit of each device, bit k for device k |
| rb_valid | input | 1 | The three bits are valid this cycle |
| upset_flag | output | 3 | Device k is upset or being refreshed |
| refresh_pulse | output | 3 | Single-cycle refresh request for device k |
| frame_done | output | 1 | One-cycle marker after the last bit of a frame |
| fatal_mismatch | output | 1 | Sticky unresolvable disagreement |

## Verification
The hardest state to reach is the two-device vote in R7. A device has to be upset in one frame, receive its pulse, and then sit outside the vote for the next frame while the other two streams are made to split. The stimulus builds frames bit by bit, places chosen flips at chosen positions and inserts idle strobes, so each frame boundary is controlled. The fatal cases are each preceded by a reset, because the flag is sticky.

// File: rtl/rbv_pkg.sv
package rbv_pkg;
    localparam int NUM_DEV = 3;

    typedef enum logic [1:0] {
        DEV_OK      = 2'd0,
        DEV_SUSPECT = 2'd1,
        DEV_REFRESH = 2'd2
    } dev_state_e;

    typedef struct packed {
        dev_state_e [NUM_DEV-1:0] st;
        logic [NUM_DEV-1:0]       pulse;
        logic                     fatal;
    } vote_state_t;
endpackage

// File: rtl/rbv_frame_counter.sv
module rbv_frame_counter #(
    parameter int FRAME_BITS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    output logic frame_last,
    output logic frame_done
);
    localparam int CNT_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             done_d, done_q;

    always_comb begin
        cnt_d      = cnt_q;
        frame_last = bit_valid && (cnt_q == LAST);
        done_d     = frame_last;
        if (bit_valid) begin
            cnt_d = frame_last ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            done_q <= done_d;
        end
    end

    assign frame_done = done_q;

    // R1: a frame marker never lasts two cycles
    assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R1: count stays inside the frame
    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/rbv_majority.sv
module rbv_majority
    import rbv_pkg::*;
(
    input  logic [NUM_DEV-1:0] bits,
    input  logic [NUM_DEV-1:0] active,
    output logic [NUM_DEV-1:0] outlier,
    output logic               pair_split
);
    logic all_active;
    assign all_active = &active;

    for (genvar k = 0; k < NUM_DEV; k++) begin : g_dev
        localparam int N1 = (k + 1) % NUM_DEV;
        localparam int N2 = (k + 2) % NUM_DEV;
        assign outlier[k] = all_active && (bits[N1] == bits[N2]) && (bits[k] != bits[N1]);
    end

    // exactly two voters left: they split when the parity of their bits is odd
    assign pair_split = ($countones(active) == 2) && (^(bits & active));
endmodule

// File: rtl/triple_readback_voter.sv
module triple_readback_voter
    import rbv_pkg::*;
#(
    parameter int FRAME_BITS = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] rb_bits,
    input  logic       rb_valid,
    output logic [2:0] upset_flag,
    output logic [2:0] refresh_pulse,
    output logic       frame_done,
    output logic       fatal_mismatch
);
    vote_state_t        d, q;
    logic               frame_last;
    logic [NUM_DEV-1:0] active, outlier, suspect;
    logic               pair_split;

    rbv_frame_counter #(.FRAME_BITS(FRAME_BITS)) i_frame_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_valid  (rb_valid),
        .frame_last (frame_last),
        .frame_done (frame_done)
    );

    for (genvar k = 0; k < NUM_DEV; k++) begin : g_mask
        assign active[k]  = (q.st[k] != DEV_REFRESH);
        assign suspect[k] = (q.st[k] == DEV_SUSPECT);
    end

    rbv_majority i_majority (
        .bits       (rb_bits),
        .active     (active),
        .outlier    (outlier),
        .pair_split (pair_split)
    );

    always_comb begin
        d       = q;
        d.pulse = '0;
        if (rb_valid && !q.fatal) begin
            for (int k = 0; k < NUM_DEV; k++) begin
                if (outlier[k] && !suspect[k]) begin
                    if (|(suspect & ~(NUM_DEV'(1) << k))) begin
                        d.fatal = 1'b1;
                    end else begin
                        d.st[k] = DEV_SUSPECT;
                    end
                end
            end
            if (pair_split) begin
                d.fatal = 1'b1;
            end
        end
        if (frame_last) begin
            for (int k = 0; k < NUM_DEV; k++) begin
                if (d.st[k] == DEV_SUSPECT) begin
                    if (d.fatal) begin
                        d.st[k] = DEV_OK;
                    end else begin
                        d.st[k]    = DEV_REFRESH;
                        d.pulse[k] = 1'b1;
                    end
                end else if (d.st[k] == DEV_REFRESH) begin
                    d.st[k] = DEV_OK;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    for (genvar k = 0; k < NUM_DEV; k++) begin : g_out
        assign upset_flag[k] = (q.st[k] != DEV_OK);
    end
    assign refresh_pulse  = q.pulse;
    assign fatal_mismatch = q.fatal;

    assert_flag_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(upset_flag));
    assert_pulse_frame_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|refresh_pulse) |-> frame_done);
    assert_pulse_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|refresh_pulse) |=> (refresh_pulse == '0));
    assert_pulse_flagged_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((upset_flag & refresh_pulse) == refresh_pulse));
    assert_fatal_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_mismatch |=> fatal_mismatch);
    assert_no_pulse_fatal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_mismatch |-> (refresh_pulse == '0));
endmodule

// File: tb/test_triple_readback_voter.sv
`timescale 1ns/1ps
module test_triple_readback_voter;
    localparam int F = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] rb_bits = '0;
    logic       rb_valid = 1'b0;
    logic [2:0] upset_flag, refresh_pulse;
    logic       frame_done, fatal_mismatch;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // behavioural reference: 0 ok, 1 suspect, 2 refreshing
    int       m_cnt;
    int       m_st [3];
    bit       m_fatal;
    bit [2:0] m_pulse;
    bit       m_done;

    always #5 clk = ~clk;

    triple_readback_voter #(.FRAME_BITS(F)) i_triple_readback_voter (
        .clk            (clk),
        .rst_n          (rst_n),
        .rb_bits        (rb_bits),
        .rb_valid       (rb_valid),
        .upset_flag     (upset_flag),
        .refresh_pulse  (refresh_pulse),
        .frame_done     (frame_done),
        .fatal_mismatch (fatal_mismatch)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit [2:0] m_flags();
        bit [2:0] f;
        for (int k = 0; k < 3; k++) f[k] = (m_st[k] != 0);
        return f;
    endfunction

    task automatic m_reset();
        m_cnt = 0; m_fatal = 0; m_pulse = 0; m_done = 0;
        for (int k = 0; k < 3; k++) m_st[k] = 0;
    endtask

    task automatic m_update(input bit v, input bit [2:0] b);
        int masked, odd, nact;
        bit other;
        m_pulse = 0; m_done = 0;
        if (!v) return;
        if (!m_fatal) begin
            nact = 0; masked = -1;
            for (int k = 0; k < 3; k++) if (m_st[k] == 2) masked = k; else nact++;
            if (nact == 3) begin
                odd = -1;
                if (b[1] == b[2] && b[0] != b[1]) odd = 0;
                if (b[0] == b[2] && b[1] != b[0]) odd = 1;
                if (b[0] == b[1] && b[2] != b[0]) odd = 2;
                if (odd >= 0 && m_st[odd] != 1) begin
                    other = 0;
                    for (int k = 0; k < 3; k++) if (k != odd && m_st[k] == 1) other = 1;
                    if (other) m_fatal = 1; else m_st[odd] = 1;
                end
            end else if (nact == 2) begin
                if (b[(masked + 1) % 3] != b[(masked + 2) % 3]) m_fatal = 1;
            end
        end
        if (m_cnt == F - 1) begin
            m_cnt = 0; m_done = 1;
            for (int k = 0; k < 3; k++) begin
                if (m_st[k] == 1) begin
                    if (m_fatal) m_st[k] = 0;
                    else begin m_st[k] = 2; m_pulse[k] = 1; end
                end else if (m_st[k] == 2) m_st[k] = 0;
            end
        end else begin
            m_cnt++;
        end
    endtask

    task automatic compare_all();
        chk("R1 frame_done", frame_done, m_done);
        chk("R3 upset_flag", upset_flag, m_flags());
        chk("R4 refresh_pulse", refresh_pulse, m_pulse);
        chk("R6 fatal_mismatch", fatal_mismatch, m_fatal);
    endtask

    // one clock: drive at negedge, model after posedge, compare at next negedge
    task automatic step(input bit v, input bit [2:0] b);
        rb_valid = v; rb_bits = b;
        @(posedge clk);
        m_update(v, b);
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rb_valid = 1'b0;
        @(posedge clk); @(posedge clk);
        m_reset();
        @(negedge clk);
        chk("R9 reset outputs", {upset_flag, refresh_pulse, frame_done, fatal_mismatch}, 0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R9 after reset", {upset_flag, refresh_pulse, frame_done, fatal_mismatch}, 0);
    endtask

    // a frame of F valid bits; device da flipped at pa, db flipped at pb (-1 none)
    task automatic run_frame(input int da, input int pa, input int db, input int pb,
                             input int chk_at, input bit [2:0] chk_flag);
        for (int n = 0; n < F; n++) begin
            bit [2:0] b;
            b = {3{1'($urandom)}};
            if (n % 5 == 2) step(1'b0, 3'($urandom)); // idle strobe, R1
            if (da >= 0 && (n == pa || n == pa + 4)) b[da] = ~b[da];
            if (db >= 0 && n == pb) b[db] = ~b[db];
            step(1'b1, b);
            if (n == chk_at) chk("R3 flag after outlier bit", upset_flag, chk_flag);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        m_reset();
        @(negedge clk);
        do_reset();

        // R2: clean frames
        run_frame(-1, 0, -1, 0, 5, 3'b000);
        chk("R1 done at frame end", frame_done, 1);
        chk("R2 clean no flag", upset_flag, 0);
        step(1'b0, 3'b000);
        chk("R1 done one cycle", frame_done, 0);

        // R3/R4: device 1 outlier twice in one frame
        run_frame(1, 3, -1, 0, 3, 3'b010);
        chk("R4 single pulse dev1", refresh_pulse, 3'b010);
        step(1'b0, 3'b000);
        chk("R4 pulse one cycle", refresh_pulse, 0);

        // R5: device 1 masked, its flips ignored
        run_frame(1, 1, -1, 0, 8, 3'b010);
        chk("R5 mask frame end no pulse", refresh_pulse, 0);
        chk("R5 flag cleared", upset_flag, 0);
        chk("R5 no fatal", fatal_mismatch, 0);

        // R3/R4: outlier on the last bit of a frame
        run_frame(2, 15, -1, 0, 15, 3'b100);
        chk("R4 pulse for last-bit outlier", refresh_pulse, 3'b100);
        run_frame(-1, 0, -1, 0, 0, 3'b100);

        // R6: two devices stray in one frame
        run_frame(0, 2, 2, 10, 2, 3'b001);
        chk("R6 fatal raised", fatal_mismatch, 1);
        chk("R6 no pulse", refresh_pulse, 0);
        chk("R6 flag cleared", upset_flag, 0);
        // R8: vote frozen
        run_frame(1, 4, -1, 0, 4, 3'b000);
        chk("R8 frame_done continues", frame_done, 1);
        chk("R8 no pulse", refresh_pulse, 0);
        chk("R8 fatal held", fatal_mismatch, 1);

        // R7: two-device split while one is masked
        do_reset();
        run_frame(2, 6, -1, 0, 6, 3'b100);
        run_frame(0, 9, -1, 0, 9, 3'b100);
        chk("R7 split fatal", fatal_mismatch, 1);

        // random mixture
        do_reset();
        for (int r = 0; r < 40; r++) begin
            int da;
            da = ($urandom % 4 == 0) ? int'($urandom % 3) : -1;
            run_frame(da, int'($urandom % 10), -1, 0, -1, 3'b000);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule